// File: doc/BRIEF.md
# Segment-Shared Key Matrix Scanner

This block collects the state of a 20-key matrix whose ten drive lines are the same pins that drive display segments. The display scanner inserts a short key-drive slot for each segment line at the end of its frame. During a slot it presents the line index and a phase flag. The scanner samples the two return inputs in the second half of the slot and holds the result in a capture store.

A frame-end pulse moves the whole capture store in one step into a readable key buffer and clears the capture store for the next frame. A serial read path outside this block sees the key buffer as five bytes. It selects a byte and a bit and gets back both the selected byte and the selected bit. Each byte carries two neighbouring drive lines in a fixed sparse layout. The bits that are not used always read as zero.

Top module: `keymx_scan`

## Requirements
- R1: When `scan_act` and `scan_half` are both high at a rising clock edge, `key_ret[0]` (first return) and `key_ret[1]` (second return) are captured for drive line `scan_line` (0-based, 0 to 9).
- R2: No capture takes place while `scan_act` is low or `scan_half` is low (the first half of a slot).
- R3: A `frame_end` pulse moves the capture store into the readable buffer. The new content is visible on the read outputs from the cycle after that edge. A capture made at the same edge as `frame_end` is included in the commit.
- R4: Between `frame_end` pulses the readable buffer does not change, even while new captures are being taken.
- R5: Each `frame_end` clears the capture store. A line that is not captured in the following frame therefore reads as zero after the next commit.
- R6: Byte b (0 to 4) holds drive line 2b in bit 0 (first return) and bit 1 (second return). It holds drive line 2b+1 in bit 3 (first return) and bit 4 (second return).
- R7: Bits 2, 5, 6 and 7 of every key byte read as 0.
- R8: `key_bit` equals bit `rd_bit` of byte `rd_byte`. Serial order is bit 0 to 7 of byte 0, then byte 1, and so on up to byte 4.
- R9: A `rd_byte` value of 5 or higher reads as byte 0x00 and bit 0. A `scan_line` value of 10 or higher captures nothing.
- R10: After reset the buffer reads all zeros. The internal reset is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_act | input | 1 | A key-drive slot is active |
| scan_half | input | 1 | Second half of the current slot (sample window) |
| scan_line | input | 4 | Index of the drive line in the current slot |
| key_ret | input | 2 | Return inputs (bit 0 = first, bit 1 = second) |
| frame_end | input | 1 | One-cycle pulse at the end of a display frame |
| rd_byte | input | 3 | Byte select for readback |
| rd_bit | input | 3 | Bit select within the selected byte |
| key_byte | output | 8 | Selected packed key byte |
| key_bit | output | 1 | Selected bit of the selected byte |

## Verification
The bench builds the block with its default ten drive lines. That gives a 4-bit line index and a 3-bit byte select. Line indices 10 to 15 and byte selects 5 to 7 can therefore be driven from the ports, so the out-of-range rules are exercised directly. With five full bytes, the sparse layout, the serial order across every byte boundary, and a capture that lands in the same cycle as a commit can all be checked against a model in the bench.

// File: rtl/keymx_pkg.sv
package keymx_pkg;
  localparam int RET_N    = 2;  // return inputs per drive line
  localparam int BYTE_W   = 8;
  localparam int HI_OFS   = 3;  // bit offset of the odd line of a pair

  function automatic logic [BYTE_W-1:0] pack_pair(input logic [RET_N-1:0] lo,
                                                  input logic [RET_N-1:0] hi);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[RET_N-1:0]             = lo;
    b[HI_OFS +: RET_N]       = hi;
    return b;
  endfunction
endpackage

// File: rtl/keymx_capture.sv
module keymx_capture #(
  parameter int NUM_DRV = 10,
  parameter int LINE_W  = 4,
  parameter int RET_N   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_fire,
  input  logic [LINE_W-1:0]        line,
  input  logic [RET_N-1:0]         ret,
  input  logic                     clr,
  output logic [NUM_DRV*RET_N-1:0] shadow_q,
  output logic [NUM_DRV*RET_N-1:0] merged
);
  logic [NUM_DRV*RET_N-1:0] shadow_d;
  logic                     shadow_en;

  // Current store with this cycle's sample folded in.
  for (genvar i = 0; i < NUM_DRV; i++) begin : g_slot
    always_comb begin
      if (smp_fire && (line == LINE_W'(i)))
        merged[i*RET_N +: RET_N] = ret;
      else
        merged[i*RET_N +: RET_N] = shadow_q[i*RET_N +: RET_N];
    end
  end

  always_comb begin
    shadow_en = smp_fire | clr;
    shadow_d  = clr ? '0 : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end
endmodule

// File: rtl/keymx_store.sv
module keymx_store #(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] frame_in,
  output logic [DATA_W-1:0] stored_q
);
  logic [DATA_W-1:0] stored_d;

  always_comb stored_d = frame_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stored_q <= '0;
    else if (commit) stored_q <= stored_d;
  end
endmodule

// File: rtl/keymx_pack.sv
module keymx_pack
  import keymx_pkg::*;
#(
  parameter int NUM_DRV = 10,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_DRV*RET_N-1:0] stored,
  input  logic [SEL_W-1:0]         rd_byte,
  input  logic [2:0]               rd_bit,
  output logic [BYTE_W-1:0]        key_byte,
  output logic                     key_bit
);
  localparam int NUM_BYTES = NUM_DRV / 2;
  localparam int PAIR_W    = 2 * RET_N;

  logic [BYTE_W-1:0] bytes [NUM_BYTES];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_comb bytes[b] = pack_pair(stored[b*PAIR_W +: RET_N],
                                     stored[b*PAIR_W + RET_N +: RET_N]);
  end

  always_comb begin
    key_byte = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (rd_byte == SEL_W'(b)) key_byte = bytes[b];
    key_bit = key_byte[rd_bit];
  end
endmodule

// File: rtl/keymx_scan.sv
module keymx_scan
  import keymx_pkg::*;
#(
  parameter int NUM_DRV = 10,
  localparam int LINE_W = $clog2(NUM_DRV),
  localparam int SEL_W  = $clog2(NUM_DRV / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_act,
  input  logic              scan_half,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [RET_N-1:0]  key_ret,
  input  logic              frame_end,
  input  logic [SEL_W-1:0]  rd_byte,
  input  logic [2:0]        rd_bit,
  output logic [BYTE_W-1:0] key_byte,
  output logic              key_bit
);
  localparam int KEY_BITS = NUM_DRV * RET_N;

  logic                rst_meta, rst_q_n;
  logic                smp_fire;
  logic [KEY_BITS-1:0] shadow_q, merged, stored_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  always_comb smp_fire = scan_act & scan_half;

  keymx_capture #(.NUM_DRV(NUM_DRV), .LINE_W(LINE_W), .RET_N(RET_N)) cap_i (
    .clk(clk), .rst_n(rst_q_n), .smp_fire(smp_fire), .line(scan_line),
    .ret(key_ret), .clr(frame_end), .shadow_q(shadow_q), .merged(merged));

  keymx_store #(.DATA_W(KEY_BITS)) sto_i (
    .clk(clk), .rst_n(rst_q_n), .commit(frame_end),
    .frame_in(merged), .stored_q(stored_q));

  keymx_pack #(.NUM_DRV(NUM_DRV), .SEL_W(SEL_W)) pck_i (
    .stored(stored_q), .rd_byte(rd_byte), .rd_bit(rd_bit),
    .key_byte(key_byte), .key_bit(key_bit));
endmodule

// File: rtl/keymx_scan_chk.sv
module keymx_scan_chk #(
  parameter int KEY_BITS = 20,
  parameter int SEL_W    = 3,
  parameter int NUM_BYTES = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_fire,
  input logic                frame_end,
  input logic [KEY_BITS-1:0] shadow_q,
  input logic [KEY_BITS-1:0] merged,
  input logic [KEY_BITS-1:0] stored_q,
  input logic [SEL_W-1:0]    rd_byte,
  input logic [7:0]          key_byte,
  input logic                key_bit
);
  a_r2_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_fire && !frame_end) |=> $stable(shadow_q));

  a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (stored_q == $past(merged)));

  a_r4_atomic_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(stored_q));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (shadow_q == '0));

  a_r9_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_byte >= SEL_W'(NUM_BYTES)) |-> (key_byte == 8'h00 && !key_bit));
endmodule

bind keymx_scan keymx_scan_chk #(.KEY_BITS(KEY_BITS), .SEL_W(SEL_W), .NUM_BYTES(NUM_DRV / 2)) chk_i (
  .clk(clk), .rst_n(rst_q_n), .smp_fire(smp_fire), .frame_end(frame_end),
  .shadow_q(shadow_q), .merged(merged), .stored_q(stored_q),
  .rd_byte(rd_byte), .key_byte(key_byte), .key_bit(key_bit));

// File: tb/keymx_scan_tb.sv
module keymx_scan_tb_top;
  localparam int NDRV = 10;
  localparam int NBYTE = 5;

  logic       clk, rst_n;
  logic       scan_act, scan_half, frame_end;
  logic [3:0] scan_line;
  logic [1:0] key_ret;
  logic [2:0] rd_byte, rd_bit;
  logic [7:0] key_byte;
  logic       key_bit;

  int checks = 0, fails = 0;
  logic [1:0] model [NDRV];   // committed frame expected at the ports

  keymx_scan dut_i (.clk(clk), .rst_n(rst_n), .scan_act(scan_act), .scan_half(scan_half),
    .scan_line(scan_line), .key_ret(key_ret), .frame_end(frame_end),
    .rd_byte(rd_byte), .rd_bit(rd_bit), .key_byte(key_byte), .key_bit(key_bit));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // R6/R7 layout: even line in bits 1:0, odd line in bits 4:3, rest zero.
  function automatic logic [7:0] exp_byte(input int b);
    if (b >= NBYTE) return 8'h00;
    return {3'b000, model[2*b+1], 1'b0, model[2*b]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int b = 0; b < NBYTE; b++) begin
      rd_byte = 3'(b); rd_bit = 3'd0;
      #1;
      chk(req, key_byte, exp_byte(b));
    end
  endtask

  task automatic samp(input int line, input logic [1:0] ret, input logic act, input logic half);
    @(negedge clk);
    scan_act = act; scan_half = half; scan_line = 4'(line); key_ret = ret;
    @(negedge clk);
    scan_act = 1'b0; scan_half = 1'b0; key_ret = 2'b00;
  endtask

  task automatic commit_frame();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic model_clear();
    for (int i = 0; i < NDRV; i++) model[i] = 2'b00;
  endtask

  task automatic t_reset();
    model_clear();
    chk_all("R10 reset");
    rd_byte = 3'd2; rd_bit = 3'd3; #1;
    chk("R10 reset bit", {7'd0, key_bit}, 8'h00);
  endtask

  task automatic t_keys();
    for (int i = 0; i < NDRV; i++) begin
      model[i] = 2'((i % 3) + 1);
      samp(i, model[i], 1'b1, 1'b1);
    end
    commit_frame();
    chk_all("R1 R6 capture pattern A");
    for (int i = 0; i < NDRV; i++) begin
      model[i] = 2'(3 - (i % 4));
      samp(i, model[i], 1'b1, 1'b1);
    end
    commit_frame();
    chk_all("R1 R6 capture pattern B");
  endtask

  task automatic t_dont_care();
    for (int i = 0; i < NDRV; i++) begin
      model[i] = 2'b11;
      samp(i, 2'b11, 1'b1, 1'b1);
    end
    commit_frame();
    for (int b = 0; b < NBYTE; b++) begin
      rd_byte = 3'(b); #1;
      chk("R7 unused bits zero", key_byte, 8'h1B);
    end
  endtask

  task automatic t_first_half();
    samp(3, 2'b11, 1'b1, 1'b0);
    samp(4, 2'b11, 1'b0, 1'b1);
    commit_frame();
    model_clear();
    chk_all("R2 no capture outside sample window");
  endtask

  task automatic t_atomic();
    samp(0, 2'b11, 1'b1, 1'b1);
    commit_frame();
    model_clear(); model[0] = 2'b11;
    chk_all("R3 commit frame A");
    samp(1, 2'b11, 1'b1, 1'b1);
    samp(2, 2'b01, 1'b1, 1'b1);
    chk_all("R4 buffer held mid-frame");
    commit_frame();
    model_clear(); model[1] = 2'b11; model[2] = 2'b01;
    chk_all("R5 old line cleared after next commit");
  endtask

  task automatic t_coincide();
    rd_byte = 3'd4; rd_bit = 3'd0;
    @(negedge clk);
    frame_end = 1'b1; scan_act = 1'b1; scan_half = 1'b1; scan_line = 4'd9; key_ret = 2'b10;
    #1;
    chk("R3 unchanged before commit edge", key_byte, exp_byte(4));
    @(negedge clk);
    frame_end = 1'b0; scan_act = 1'b0; scan_half = 1'b0; key_ret = 2'b00;
    model_clear(); model[9] = 2'b10;
    #1;
    chk("R3 same-edge sample included", key_byte, 8'h10);
    commit_frame();
    model_clear();
    chk_all("R5 empty frame commits zeros");
  endtask

  task automatic t_serial();
    for (int i = 0; i < NDRV; i++) begin
      model[i] = 2'((i * 7 + 1) % 4);
      samp(i, model[i], 1'b1, 1'b1);
    end
    commit_frame();
    for (int n = 0; n < NBYTE * 8; n++) begin
      logic [7:0] e;
      rd_byte = 3'(n / 8); rd_bit = 3'(n % 8);
      #1;
      e = exp_byte(n / 8);
      chk($sformatf("R8 serial bit %0d", n), {7'd0, key_bit}, {7'd0, e[n % 8]});
    end
  endtask

  task automatic t_range();
    for (int b = NBYTE; b < 8; b++) begin
      rd_byte = 3'(b); rd_bit = 3'd0; #1;
      chk("R9 byte out of range", key_byte, 8'h00);
      for (int k = 0; k < 8; k++) begin
        rd_bit = 3'(k); #1;
        chk("R9 bit out of range", {7'd0, key_bit}, 8'h00);
      end
    end
    samp(12, 2'b11, 1'b1, 1'b1);
    samp(15, 2'b11, 1'b1, 1'b1);
    commit_frame();
    model_clear();
    chk_all("R9 line out of range ignored");
  endtask

  initial begin
    rst_n = 1'b0; scan_act = 1'b0; scan_half = 1'b0; scan_line = 4'd0;
    key_ret = 2'b00; frame_end = 1'b0; rd_byte = 3'd0; rd_bit = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: a capture on the first edge after release is lost to reset sync
    samp(0, 2'b11, 1'b1, 1'b1);
    @(negedge clk);
    t_reset();
    t_keys();
    t_dont_care();
    t_first_half();
    t_atomic();
    t_coincide();
    t_serial();
    t_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule